// File: doc/BRIEF.md
# SIMD Broadcast Processing-Element Array

This block is an array of identical processing elements that all listen to one instruction stream. Each clock cycle a single control port presents one decoded instruction: an opcode, a destination register index, a source register index, a local memory address and a mask vector. Every element that is currently active carries out that instruction on its own private register file and its own private data memory. A per-element activity flag lets the issuing controller switch elements off, so that they skip an instruction entirely.

Data is spread across the elements: element i keeps element i of each vector in its own memory. A vector operation therefore takes the same short sequence of broadcast steps whatever the vector length, up to the element count. A host test port with an element index, an address, a write enable and write data preloads any element's memory and reads it back. When the host writes the same location in the same cycle as a broadcast store, the host write wins.

Top module: `simd_pe_array`

## Requirements
- R1: A synchronous reset makes every element active and clears every register of every element to zero. Memory contents are not reset.
- R2: Opcode 1 (LOAD) writes location `addr_i` of each active element's own memory into that element's register `rd_i`.
- R3: Opcode 2 (STORE) writes register `rs_i` of each active element into location `addr_i` of that element's own memory.
- R4: Opcode 3 (ADD) sets Rd to Rd + Rs in each active element, wrapping modulo 2^16 and raising no flag.
- R5: Opcode 4 (SUB) sets Rd to Rd - Rs in each active element, wrapping modulo 2^16.
- R6: Opcode 5 (MOV) copies Rs into Rd in each active element.
- R7: Opcode 6 (SETMASK) sets the activity flag of element i to `mask_i[i]` in every element, idle ones included. An idle element performs no register write and no memory write for any other opcode.
- R8: Opcode 0 and every code from 7 to 15 change no register, no memory location and no activity flag.
- R9: The register written by a LOAD holds its new value for the instruction issued in the very next cycle, with no stall.
- R10: A host write (`host_we_i` high) stores `host_wdata_i` at `host_addr_i` of element `host_pe_i` only. A host read presented in cycle t appears on `host_rdata_o` after the second rising edge from t.
- R11: When a host write and a broadcast STORE hit the same element and address in the same cycle, the host data is kept; when the addresses differ, both writes take effect.
- R12: A vector add of a at local address 0 and b at local address 1 finishes in four broadcast steps (LOAD, LOAD, ADD, STORE), with each element's sum in its own memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Broadcast opcode |
| rd_i | input | 3 | Destination register index |
| rs_i | input | 3 | Source register index |
| addr_i | input | 6 | Local memory address for LOAD and STORE |
| mask_i | input | 8 | Activity vector for SETMASK, bit i for element i |
| host_pe_i | input | 3 | Element selected by the host test port |
| host_addr_i | input | 6 | Host test port memory address |
| host_we_i | input | 1 | Host test port write enable |
| host_wdata_i | input | 16 | Host test port write data |
| host_rdata_o | output | 16 | Host test port read data, registered |

## Verification
Two functions can land in the same cycle: a host test-port write and a broadcast STORE aimed at the same element and the same local address. A LOAD can also read the location the host is overwriting. The bench drives directed cases: a host write and a STORE to one address, a host write and a STORE to different addresses, and a LOAD paired with a host write. It also scatters host writes at random through a random instruction stream. The outcome is judged against a bench model that applies the broadcast effects first, with loads reading the old contents, and then the host write. Every memory word of every element is compared through the host port.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_LOAD    = 4'd1,
    OP_STORE   = 4'd2,
    OP_ADD     = 4'd3,
    OP_SUB     = 4'd4,
    OP_MOV     = 4'd5,
    OP_SETMASK = 4'd6
  } simd_op_e;

  // true for opcodes whose result comes from the element ALU
  function automatic logic is_alu_op(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MOV);
  endfunction

endpackage

// File: rtl/simd_pe_ram.sv
module simd_pe_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);

  logic [DW-1:0] mem [DEPTH];

  // two-port, read-first; port b is written last so it wins a collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int N_REG  = 8,
  parameter int DEPTH  = 64,
  localparam int RW    = $clog2(N_REG),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [RW-1:0]   rd_i,
  input  logic [RW-1:0]   rs_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            mask_bit_i,
  input  logic            host_we_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [DW-1:0]   host_q_o,
  output logic            active_o,
  output logic            bwe_o
);

  logic [DW-1:0] rf [N_REG];
  logic          active;
  logic          ld_pend;
  logic [RW-1:0] ld_rd;

  logic [DW-1:0] ram_a_q;
  logic [DW-1:0] src_val;
  logic [DW-1:0] dst_val;
  logic [DW-1:0] alu_val;
  logic          alu_we;
  logic          st_req;
  logic          collide;
  logic          ram_a_we;

  // bypass: a load issued last cycle is still on the RAM output
  always_comb begin
    src_val = (ld_pend && (ld_rd == rs_i)) ? ram_a_q : rf[rs_i];
    dst_val = (ld_pend && (ld_rd == rd_i)) ? ram_a_q : rf[rd_i];
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:  alu_val = dst_val + src_val;
      OP_SUB:  alu_val = dst_val - src_val;
      default: alu_val = src_val;
    endcase
  end

  always_comb begin
    alu_we   = active && is_alu_op(op_i);
    st_req   = active && (op_i == OP_STORE);
    collide  = host_we_i && (host_addr_i == addr_i);
    ram_a_we = st_req && !collide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b1;
      ld_pend <= 1'b0;
      ld_rd   <= '0;
      for (int r = 0; r < N_REG; r++) rf[r] <= '0;
    end else begin
      if (ld_pend) rf[ld_rd] <= ram_a_q;
      if (alu_we) rf[rd_i] <= alu_val;
      ld_pend <= active && (op_i == OP_LOAD);
      if (op_i == OP_LOAD) ld_rd <= rd_i;
      if (op_i == OP_SETMASK) active <= mask_bit_i;
    end
  end

  simd_pe_ram #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_ram (
    .clk     (clk),
    .a_addr  (addr_i),
    .a_we    (ram_a_we),
    .a_wdata (src_val),
    .a_q     (ram_a_q),
    .b_addr  (host_addr_i),
    .b_we    (host_we_i),
    .b_wdata (host_wdata_i),
    .b_q     (host_q_o)
  );

  assign active_o = active;
  assign bwe_o    = ram_a_we;

endmodule

// File: rtl/simd_host_rd.sv
module simd_host_rd #(
  parameter int N_PE  = 8,
  parameter int DW    = 16,
  localparam int PE_W = $clog2(N_PE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PE_W-1:0] sel_i,
  input  logic [DW-1:0]   q_i [N_PE],
  output logic [DW-1:0]   rdata_o
);

  logic [PE_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      rdata_o <= '0;
    end else begin
      sel_q <= sel_i;
      if (32'(sel_q) < N_PE) rdata_o <= q_i[sel_q];
      else                   rdata_o <= '0;
    end
  end

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int N_PE      = 8,
  parameter int N_REG     = 8,
  parameter int DW        = 16,
  parameter int MEM_DEPTH = 64,
  localparam int PE_W     = $clog2(N_PE),
  localparam int REG_W    = $clog2(N_REG),
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic [REG_W-1:0]  rs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PE-1:0]   mask_i,
  input  logic [PE_W-1:0]   host_pe_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_we_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o
);

  logic [DW-1:0] host_q [N_PE];
  logic [N_PE-1:0] act_vec;
  logic [N_PE-1:0] bwe_vec;
  logic [N_PE-1:0] hwe_vec;

  for (genvar g = 0; g < N_PE; g++) begin : g_pe
    assign hwe_vec[g] = host_we_i && (32'(host_pe_i) == g);

    simd_pe #(
      .DW    (DW),
      .N_REG (N_REG),
      .DEPTH (MEM_DEPTH)
    ) u_pe (
      .clk          (clk),
      .rst          (rst),
      .op_i         (op_i),
      .rd_i         (rd_i),
      .rs_i         (rs_i),
      .addr_i       (addr_i),
      .mask_bit_i   (mask_i[g]),
      .host_we_i    (hwe_vec[g]),
      .host_addr_i  (host_addr_i),
      .host_wdata_i (host_wdata_i),
      .host_q_o     (host_q[g]),
      .active_o     (act_vec[g]),
      .bwe_o        (bwe_vec[g])
    );
  end

  simd_host_rd #(
    .N_PE (N_PE),
    .DW   (DW)
  ) u_host_rd (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (host_pe_i),
    .q_i     (host_q),
    .rdata_o (host_rdata_o)
  );

endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk
  import simd_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int ADDR_W = 6,
  parameter int PE_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PE-1:0]   mask_i,
  input logic [PE_W-1:0]   host_pe_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_we_i,
  input logic [N_PE-1:0]   act_vec,
  input logic [N_PE-1:0]   bwe_vec,
  input logic [N_PE-1:0]   hwe_vec
);

  p_reset_all_active_r1: assert property (@(posedge clk)
    rst |=> (act_vec == '1));

  p_setmask_loads_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SETMASK) |=> (act_vec == $past(mask_i)));

  p_mask_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_SETMASK) |=> $stable(act_vec));

  p_idle_no_store_r7: assert property (@(posedge clk) disable iff (rst)
    ((bwe_vec & ~act_vec) == '0));

  p_store_only_on_store_r3: assert property (@(posedge clk) disable iff (rst)
    (bwe_vec != '0) |-> (op_i == OP_STORE));

  p_host_one_element_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hwe_vec));

  p_host_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (host_we_i && (op_i == OP_STORE) && (addr_i == host_addr_i))
      |-> !bwe_vec[host_pe_i]);

endmodule

bind simd_pe_array simd_pe_array_chk #(
  .N_PE   (N_PE),
  .ADDR_W (ADDR_W),
  .PE_W   (PE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_i        (op_i),
  .addr_i      (addr_i),
  .mask_i      (mask_i),
  .host_pe_i   (host_pe_i),
  .host_addr_i (host_addr_i),
  .host_we_i   (host_we_i),
  .act_vec     (act_vec),
  .bwe_vec     (bwe_vec),
  .hwe_vec     (hwe_vec)
);

// File: tb/simd_pe_array_tb.sv
`timescale 1ns/1ps
module simd_pe_array_tb;

  localparam int NP = 8;
  localparam int NR = 8;
  localparam int MD = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [2:0]  rd_i = '0;
  logic [2:0]  rs_i = '0;
  logic [5:0]  addr_i = '0;
  logic [7:0]  mask_i = '0;
  logic [2:0]  host_pe_i = '0;
  logic [5:0]  host_addr_i = '0;
  logic        host_we_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_rf  [NP][NR];
  logic [15:0] m_mem [NP][MD];
  logic        m_act [NP];

  always #4 clk = ~clk;

  simd_pe_array u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .rd_i(rd_i), .rs_i(rs_i),
    .addr_i(addr_i), .mask_i(mask_i), .host_pe_i(host_pe_i),
    .host_addr_i(host_addr_i), .host_we_i(host_we_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // one broadcast cycle, optionally with a host write, then the model update
  task automatic step(input logic [3:0] op, input int rd, input int rs, input int addr,
                      input logic [7:0] mask, input bit hwe, input int hpe,
                      input int haddr, input logic [15:0] hd);
    @(negedge clk);
    op_i = op; rd_i = 3'(rd); rs_i = 3'(rs); addr_i = 6'(addr); mask_i = mask;
    host_we_i = hwe; host_pe_i = 3'(hpe); host_addr_i = 6'(haddr); host_wdata_i = hd;
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      if (op == 4'd6) m_act[p] = mask[p];
      else if (m_act[p]) begin
        case (op)
          4'd1: m_rf[p][rd] = m_mem[p][addr];
          4'd2: m_mem[p][addr] = m_rf[p][rs];
          4'd3: m_rf[p][rd] = m_rf[p][rd] + m_rf[p][rs];
          4'd4: m_rf[p][rd] = m_rf[p][rd] - m_rf[p][rs];
          4'd5: m_rf[p][rd] = m_rf[p][rs];
          default: ;
        endcase
      end
    end
    if (hwe) m_mem[hpe][haddr] = hd;
  endtask

  task automatic hwrite(input int p, input int a, input logic [15:0] d);
    step(4'd0, 0, 0, 0, 8'h00, 1'b1, p, a, d);
  endtask

  task automatic hread(input int p, input int a, output logic [15:0] d);
    @(negedge clk);
    op_i = 4'd0; host_we_i = 1'b0; host_pe_i = 3'(p); host_addr_i = 6'(a);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = host_rdata_o;
  endtask

  task automatic cmp(input string tag, input int p, input int a);
    logic [15:0] d;
    hread(p, a, d);
    check(tag, d, m_mem[p][a]);
  endtask

  task automatic dump(input string tag);
    step(4'd6, 0, 0, 0, 8'hFF, 1'b0, 0, 0, 16'h0);
    for (int r = 0; r < NR; r++) step(4'd2, 0, r, 56 + r, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < MD; a++) cmp(tag, p, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, va, vb;
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      m_act[p] = 1'b1;
      for (int r = 0; r < NR; r++) m_rf[p][r] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // preload all memories through the host port, read them all back (R10)
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < MD; a++) hwrite(p, a, 16'($urandom));
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < MD; a++) cmp("R10", p, a);

    // R1: registers are zero after reset and every element stores
    for (int r = 0; r < NR; r++) step(4'd2, 0, r, 48 + r, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) begin
        hread(p, 48 + r, d);
        check("R1", d, 16'h0000);
      end

    // R12 and R4: vector add in four steps, element 0 wraps
    for (int p = 0; p < NP; p++) begin
      hwrite(p, 0, (p == 0) ? 16'hFFFF : 16'($urandom));
      hwrite(p, 1, (p == 0) ? 16'h0002 : 16'($urandom));
    end
    step(4'd1, 1, 0, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd1, 2, 0, 1, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd3, 1, 2, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 1, 2, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++) begin
      hread(p, 0, va);
      hread(p, 1, vb);
      hread(p, 2, d);
      check("R12", d, va + vb);
    end
    hread(0, 2, d);
    check("R4 wrap", d, 16'h0001);

    // R9: store the register loaded in the previous cycle
    step(4'd1, 5, 0, 3, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 5, 4, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++) cmp("R9", p, 4);

    // R5 wrap to FFFF, R6 move, R2 R3 load/store
    for (int p = 0; p < NP; p++) begin
      hwrite(p, 5, 16'h0000);
      hwrite(p, 6, 16'h0001);
      hwrite(p, 9, 16'h1230 + 16'(p));
    end
    step(4'd1, 3, 0, 5, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd1, 4, 0, 6, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd4, 3, 4, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 3, 7, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd5, 6, 4, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 6, 8, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd1, 7, 0, 9, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd0, 0, 0, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 7, 10, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++) begin
      hread(p, 7, d);  check("R5", d, 16'hFFFF);
      hread(p, 8, d);  check("R6", d, 16'h0001);
      hread(p, 10, d); check("R2 R3", d, 16'h1230 + 16'(p));
    end

    // R7: mask 8'hA5, idle elements keep memory and registers
    for (int p = 0; p < NP; p++) hwrite(p, 11, 16'h00AA);
    step(4'd6, 0, 0, 0, 8'hA5, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 4, 11, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd3, 4, 4, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd1, 4, 0, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd5, 4, 6, 0, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd6, 0, 0, 0, 8'hFF, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 4, 12, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++) begin
      hread(p, 11, d); check("R7 store", d, ((8'hA5 >> p) & 1) != 0 ? 16'h0001 : 16'h00AA);
      cmp("R7 regs", p, 12);
    end

    // R8: NOP and undefined codes change nothing, mask included
    step(4'd6, 0, 0, 0, 8'h3C, 1'b0, 0, 0, 16'h0);
    for (int c = 7; c < 16; c++) step(4'(c), 4, 3, 12, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd0, 4, 3, 12, 8'h00, 1'b0, 0, 0, 16'h0);
    step(4'd2, 0, 3, 13, 8'h00, 1'b0, 0, 0, 16'h0);
    for (int p = 0; p < NP; p++) begin
      cmp("R8 mem", p, 12);
      cmp("R8 mask", p, 13);
    end
    step(4'd6, 0, 0, 0, 8'hFF, 1'b0, 0, 0, 16'h0);

    // R11: host write against store, same and different address; load with host write
    step(4'd2, 0, 4, 14, 8'h00, 1'b1, 3, 14, 16'hBEEF);
    step(4'd2, 0, 4, 16, 8'h00, 1'b1, 5, 15, 16'hCAFE);
    step(4'd1, 2, 0, 9, 8'h00, 1'b1, 6, 9, 16'h7777);
    step(4'd2, 0, 2, 17, 8'h00, 1'b0, 0, 0, 16'h0);
    hread(3, 14, d); check("R11 same", d, 16'hBEEF);
    hread(5, 15, d); check("R11 diff host", d, 16'hCAFE);
    hread(6, 17, d); check("R11 load old", d, 16'h1236);
    for (int p = 0; p < NP; p++) begin
      cmp("R11", p, 14);
      cmp("R11", p, 16);
    end

    // random instruction stream with random host writes
    for (int i = 0; i < 600; i++) begin
      step(4'($urandom_range(0, 15)), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 55), 8'($urandom), $urandom_range(0, 3) == 0,
           $urandom_range(0, 7), $urandom_range(0, 55), 16'($urandom));
      if (i % 150 == 149) dump("random mix R4 R5 R7 R11");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule